// File: doc/BRIEF.md
# Clock Output Bank Gating Divider

This block produces one bank's output clock from a distributed input clock. The input clock is passed through directly or divided by two or by four. A two-bit select stands for a three-state setting: a floating setting means pass-through, a tied-low setting means divide-by-two and a tied-high setting means divide-by-four. The divided clock keeps a 50% duty cycle. A new ratio is adopted only where one divided period ends, so a ratio change never produces a short pulse.

An enable request, which may arrive asynchronously, passes through a chain of falling-edge flops. The last flop of the chain takes a new value only while the selected clock source is low. Enabling or disabling therefore never cuts or shortens a high pulse. The block drives a true output and a complement output. When the bank is disabled, the resting levels of these outputs depend on a format flag that selects differential or single-ended mode.

Top module: `clk_bank_gate_div`

## Requirements
- R1: `div_sel` encoding: 2'b00 (floating) and 2'b11 select divide-by-1, 2'b01 (tied low) selects divide-by-2, and 2'b10 (tied high) selects divide-by-4.
- R2: The divided output has a 50% duty cycle. At divide-by-2 it is high for one input period and low for one. At divide-by-4 it is high for two input periods and low for two.
- R3: After synchronous reset is released, the first rising input edge starts the high phase of the first divided period, so banks released together stay aligned.
- R4: A change of `div_sel` takes effect only at the rising input edge that ends the current divided period. In divide-by-1 mode that is the next rising edge.
- R5: A change of `en_req` present before a falling input edge reaches the outputs at the next falling edge after that one (two falling-edge stages), provided the source is low then.
- R6: The effective enable changes only at a falling edge where the selected source is low. A disable that is requested during a divided high phase therefore lets the whole high phase finish.
- R7: With `diff_mode`=1 and the bank disabled, `q_p` is 0 and `q_n` is 1. Whenever the bank is enabled, in either format, `q_n` is the inverse of `q_p`.
- R8: With `diff_mode`=0 and the bank disabled, both `q_p` and `q_n` are 0.
- R9: Reset puts the enable stages in the enabled state, so the bank runs right after reset even while `en_req` is held low. During reset the divided source is held low.
- R10: At divide-by-1 with the bank enabled, `q_p` follows `clk_in`: high in the high phase and low in the low phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_in | input | 1 | Distributed input clock |
| rst | input | 1 | Synchronous reset, active high |
| div_sel | input | 2 | Divider setting (see R1) |
| en_req | input | 1 | Output enable request, asynchronous, 1 = enable |
| diff_mode | input | 1 | 1 = differential format, 0 = single-ended |
| q_p | output | 1 | True output clock |
| q_n | output | 1 | Complement output clock |

## Verification
A ratio boundary on a rising edge and an enable update on the falling edge just before it can fall in the same input cycle. The bench sets up this case as follows. It holds the bank disabled at divide-by-2, then requests enable and a switch to divide-by-1 together during a divided high phase. The enable then lands on the falling edge of the following low cycle, and the ratio switch lands on the next rising edge. The bench accepts the case only if the outputs show the complement going high in that low phase, followed by a clean pass-through pulse, with no early or truncated high level.

// File: rtl/cobg_pkg.sv
package cobg_pkg;

    localparam int LOG2_MAX = 2;
    localparam int CNT_W    = LOG2_MAX;

    typedef enum logic [1:0] {
        SEL_FLOAT = 2'b00,
        SEL_LOW   = 2'b01,
        SEL_HIGH  = 2'b10,
        SEL_SPARE = 2'b11
    } div_pin_e;

    // ratio held as log2 of the divide value
    typedef enum logic [1:0] {
        RAT_1 = 2'd0,
        RAT_2 = 2'd1,
        RAT_4 = 2'd2
    } ratio_e;

    typedef struct packed {
        ratio_e             ratio;
        logic [CNT_W-1:0]   idx;
        logic               level;
    } div_state_t;

    function automatic ratio_e decode_sel(input logic [1:0] sel);
        case (div_pin_e'(sel))
            SEL_LOW:  return RAT_2;
            SEL_HIGH: return RAT_4;
            default:  return RAT_1;
        endcase
    endfunction

    function automatic logic [CNT_W-1:0] last_idx(input ratio_e r);
        return CNT_W'((32'd1 << int'(r)) - 32'd1);
    endfunction

    function automatic logic [CNT_W-1:0] half_cnt(input ratio_e r);
        return CNT_W'((32'd1 << int'(r)) >> 1);
    endfunction

endpackage

// File: rtl/cobg_divider.sv
module cobg_divider
    import cobg_pkg::*;
(
    input  logic    clk_in,
    input  logic    rst,
    input  logic [1:0] sel,
    output ratio_e  ratio_o,
    output logic    level_o,
    output logic    bound_o
);

    div_state_t st_q;
    div_state_t st_d;
    ratio_e     req;
    logic       bound;
    logic [CNT_W-1:0] nxt_idx;

    always_comb begin
        req     = decode_sel(sel);
        bound   = (st_q.idx == last_idx(st_q.ratio));
        nxt_idx = st_q.idx + 1'b1;
        st_d    = st_q;
        if (bound) begin
            st_d.ratio = req;
            st_d.idx   = '0;
            st_d.level = (req != RAT_1);
        end else begin
            st_d.idx   = nxt_idx;
            st_d.level = (nxt_idx < half_cnt(st_q.ratio));
        end
    end

    always_ff @(posedge clk_in) begin
        if (rst) begin
            st_q.ratio <= req;
            st_q.idx   <= last_idx(req);
            st_q.level <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ratio_o = st_q.ratio;
    assign level_o = st_q.level;
    assign bound_o = bound;

endmodule

// File: rtl/cobg_en_sync.sv
module cobg_en_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_in,
    input  logic rst,
    input  logic en_req,
    input  logic safe,
    output logic en_on
);

    localparam int LAST = STAGES - 1;

    logic [LAST:0] sync_q;

    always_ff @(negedge clk_in) begin
        if (rst) begin
            sync_q <= '1;
        end else begin
            sync_q[0] <= en_req;
            for (int i = 1; i < LAST; i++) begin
                sync_q[i] <= sync_q[i-1];
            end
            if (safe) begin
                sync_q[LAST] <= sync_q[LAST-1];
            end
        end
    end

    assign en_on = sync_q[LAST];

endmodule

// File: rtl/cobg_out_stage.sv
module cobg_out_stage (
    input  logic src,
    input  logic en_on,
    input  logic diff_mode,
    output logic q_p,
    output logic q_n
);

    always_comb begin
        if (en_on) begin
            q_p = src;
            q_n = ~src;
        end else begin
            q_p = 1'b0;
            q_n = diff_mode;
        end
    end

endmodule

// File: rtl/clk_bank_gate_div.sv
module clk_bank_gate_div
    import cobg_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk_in,
    input  logic       rst,
    input  logic [1:0] div_sel,
    input  logic       en_req,
    input  logic       diff_mode,
    output logic       q_p,
    output logic       q_n
);

    ratio_e ratio_cur;
    logic   level;
    logic   bound;
    logic   src;
    logic   safe;
    logic   en_on;

    cobg_divider u_div (
        .clk_in  (clk_in),
        .rst     (rst),
        .sel     (div_sel),
        .ratio_o (ratio_cur),
        .level_o (level),
        .bound_o (bound)
    );

    assign src  = (ratio_cur == RAT_1) ? clk_in : level;
    assign safe = (ratio_cur == RAT_1) | ~level;

    cobg_en_sync #(.STAGES(SYNC_STAGES)) u_en (
        .clk_in (clk_in),
        .rst    (rst),
        .en_req (en_req),
        .safe   (safe),
        .en_on  (en_on)
    );

    cobg_out_stage u_out (
        .src       (src),
        .en_on     (en_on),
        .diff_mode (diff_mode),
        .q_p       (q_p),
        .q_n       (q_n)
    );

endmodule

// File: rtl/clk_bank_gate_div_chk.sv
module clk_bank_gate_div_chk
    import cobg_pkg::*;
(
    input logic   clk_in,
    input logic   rst,
    input logic   diff_mode,
    input logic   q_p,
    input logic   q_n,
    input logic   en_on,
    input ratio_e ratio_cur,
    input logic   level,
    input logic   bound,
    input logic   safe
);

    // R7
    diff_off_levels_chk: assert property (@(posedge clk_in) disable iff (rst)
        (!en_on && diff_mode) |-> (!q_p && q_n));

    // R8
    se_off_levels_chk: assert property (@(posedge clk_in) disable iff (rst)
        (!en_on && !diff_mode) |-> (!q_p && !q_n));

    // R7
    comp_inverse_chk: assert property (@(posedge clk_in) disable iff (rst)
        en_on |-> (q_n == !q_p));

    // R4
    ratio_at_bound_chk: assert property (@(posedge clk_in) disable iff (rst)
        (ratio_cur != $past(ratio_cur)) |-> $past(bound));

    // R2
    half_toggle_chk: assert property (@(posedge clk_in) disable iff (rst)
        ($past(!rst) && ratio_cur == RAT_2 && $past(ratio_cur) == RAT_2)
        |-> (level != $past(level)));

    // R6
    gate_when_low_chk: assert property (@(negedge clk_in) disable iff (rst)
        !$stable(en_on) |-> $past(safe));

endmodule

bind clk_bank_gate_div clk_bank_gate_div_chk u_chk (
    .clk_in    (clk_in),
    .rst       (rst),
    .diff_mode (diff_mode),
    .q_p       (q_p),
    .q_n       (q_n),
    .en_on     (en_on),
    .ratio_cur (ratio_cur),
    .level     (level),
    .bound     (bound),
    .safe      (safe)
);

// File: tb/tb_clk_bank_gate_div.sv
`timescale 1ns/1ps
module tb_clk_bank_gate_div;

    logic       clk_in = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] div_sel = 2'b00;
    logic       en_req = 1'b1;
    logic       diff_mode = 1'b1;
    logic       q_p;
    logic       q_n;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    clk_bank_gate_div dut (
        .clk_in    (clk_in),
        .rst       (rst),
        .div_sel   (div_sel),
        .en_req    (en_req),
        .diff_mode (diff_mode),
        .q_p       (q_p),
        .q_n       (q_n)
    );

    always #4 clk_in = ~clk_in;

    localparam int NV = 6;
    localparam logic [1:0] V_SEL [NV]  = '{2'b00, 2'b01, 2'b10, 2'b11, 2'b01, 2'b10};
    localparam logic       V_DIFF [NV] = '{1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0};
    localparam int         V_RAT [NV]  = '{1, 2, 4, 1, 2, 4};

    task automatic at_hi();
        @(posedge clk_in); #2;
    endtask

    task automatic at_lo();
        @(negedge clk_in); #2;
    endtask

    task automatic chk(input string rq, input string what, input logic got, input logic exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s: got %b expected %b", rq, what, got, exp);
        end
    endtask

    function automatic logic exp_lvl(input int r, input int k);
        if (r == 1) return 1'b1;
        return ((k % r) < (r / 2));
    endfunction

    task automatic do_reset(input logic [1:0] s, input logic d, input logic e);
        @(negedge clk_in); #1;
        rst = 1'b1; div_sel = s; diff_mode = d; en_req = e;
        repeat (3) @(posedge clk_in);
        @(negedge clk_in); #1;
        rst = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(8 * 20000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        // vector table: R1 decode, R2 duty, R3 alignment, R10 pass-through
        for (int v = 0; v < NV; v++) begin
            do_reset(V_SEL[v], V_DIFF[v], 1'b1);
            for (int k = 0; k < 8; k++) begin
                logic e;
                e = exp_lvl(V_RAT[v], k);
                at_hi();
                chk((k == 0) ? "R3" : "R1", "q_p high phase", q_p, e);
                chk("R2", "q_n high phase", q_n, ~e);
                at_lo();
                chk((V_RAT[v] == 1) ? "R10" : "R2", "q_p low phase", q_p,
                    (V_RAT[v] == 1) ? 1'b0 : e);
            end
        end

        // R9 reset default enable, R5/R6/R8 latency, plus combined enable + ratio switch
        @(negedge clk_in); #1;
        rst = 1'b1; div_sel = 2'b01; diff_mode = 1'b0; en_req = 1'b0;
        repeat (3) @(posedge clk_in);
        at_lo();
        chk("R9", "q_n in reset", q_n, 1'b1);
        chk("R9", "q_p in reset", q_p, 1'b0);
        rst = 1'b0;
        at_hi(); chk("R9", "q_p cycle0", q_p, 1'b1);
        at_lo(); chk("R6", "q_p cycle0 low", q_p, 1'b1);
        at_hi(); chk("R2", "q_p cycle1", q_p, 1'b0);
        at_lo(); chk("R8", "q_n disabled", q_n, 1'b0);
        at_hi();
        chk("R5", "q_p cycle2 disabled", q_p, 1'b0);
        chk("R8", "q_n cycle2", q_n, 1'b0);
        #1; en_req = 1'b1; div_sel = 2'b00;
        at_lo(); chk("R6", "q_n still off", q_n, 1'b0);
        at_hi(); chk("R5", "q_n cycle3 high", q_n, 1'b0);
        at_lo(); chk("R5", "q_n re-enabled", q_n, 1'b1);
        at_hi(); chk("R4", "q_p first pass pulse", q_p, 1'b1);
        at_lo(); chk("R10", "q_p pass low", q_p, 1'b0);
        at_hi(); chk("R10", "q_p pass next", q_p, 1'b1);

        // R6: disable inside a divide-by-4 high phase waits for low
        do_reset(2'b10, 1'b0, 1'b1);
        at_hi(); chk("R3", "q_p cycle0", q_p, 1'b1);
        #1; en_req = 1'b0;
        at_lo(); chk("R6", "q_p cycle0 low", q_p, 1'b1);
        at_hi(); chk("R6", "q_p cycle1", q_p, 1'b1);
        at_lo(); chk("R6", "q_p cycle1 low", q_p, 1'b1);
        at_hi(); chk("R7", "q_n cycle2 still on", q_n, 1'b1);
        at_lo(); chk("R8", "q_n off after gate", q_n, 1'b0);
        at_hi(); at_hi();
        chk("R5", "q_p cycle4 disabled", q_p, 1'b0);

        // R4: divide-by-4 to divide-by-2 mid period
        do_reset(2'b10, 1'b1, 1'b1);
        at_hi(); chk("R4", "q_p cycle0", q_p, 1'b1);
        @(negedge clk_in); #1; div_sel = 2'b01;
        for (int k = 1; k < 8; k++) begin
            logic e;
            e = (k < 4) ? exp_lvl(4, k) : exp_lvl(2, k - 4);
            at_hi();
            chk("R4", "q_p after change", q_p, e);
        end

        // R4: divide-by-1 to divide-by-2 at the next rising edge
        do_reset(2'b00, 1'b1, 1'b1);
        at_hi(); chk("R10", "q_p cycle0", q_p, 1'b1);
        at_lo(); chk("R10", "q_p cycle0 low", q_p, 1'b0);
        #1; div_sel = 2'b01;
        at_hi(); chk("R4", "q_p cycle1", q_p, 1'b1);
        at_lo(); chk("R4", "q_p cycle1 low", q_p, 1'b1);
        at_hi(); chk("R4", "q_p cycle2", q_p, 1'b0);
        at_hi(); chk("R4", "q_p cycle3", q_p, 1'b1);

        // R7: differential disabled levels and R5 two-edge latency
        do_reset(2'b00, 1'b1, 1'b1);
        at_hi(); chk("R10", "q_p cycle0", q_p, 1'b1);
        #1; en_req = 1'b0;
        at_lo(); chk("R7", "q_n cycle0 low", q_n, 1'b1);
        at_hi(); chk("R5", "q_p still on", q_p, 1'b1);
        at_lo();
        chk("R7", "q_p off", q_p, 1'b0);
        chk("R7", "q_n off", q_n, 1'b1);
        at_hi();
        chk("R7", "q_p held low", q_p, 1'b0);
        chk("R7", "q_n held high", q_n, 1'b1);

        finish_run();
    end

endmodule